// File: doc/BRIEF.md
# Single-Operand Shift/Extend Unit

This unit executes the register-mode single-operand operations of a 16-bit processor core: rotate right through carry, byte swap, arithmetic shift right and sign extension. Each cycle it takes one instruction word, the value of the addressed register and the current carry flag. It decodes the single-operand fields and computes the result, a register write strobe, a flag write strobe and new C, Z, N and V values. All outputs are registered one clock after the inputs.

Stack operations (push, call, interrupt return), memory addressing modes, byte forms of swap and sign extend, and the spare opcode are not executed here. For those the unit raises `unsup_o` and writes nothing. A word outside the single-operand format passes through with every strobe low.

Top module: `sop_shift_unit`

## Requirements
- R1: Outputs change only on a rising clock edge, one cycle after the inputs. While `rst_ni` is low, every output is zero, and this happens without waiting for a clock edge.
- R2: The rotate through carry is opcode 000. The word form gives {carry_i, op[15:1]}. The byte form gives {8'h00, carry_i, op[7:1]}. In both forms C takes op[0].
- R3: The arithmetic right shift is opcode 010. The word form gives {op[15], op[15:1]}. The byte form gives {8'h00, op[7], op[7:1]}. In both forms C takes op[0].
- R4: The swap is opcode 001 and gives {op[7:0], op[15:8]}. It writes the register and holds `flag_we_o` low.
- R5: The sign extend is opcode 011 and gives {8 copies of op[7], op[7:0]}. For this operation C is the inverse of Z.
- R6: Whenever flags are written, Z is 1 exactly when the result is zero. N is result bit 7 in byte form and bit 15 in word form. V is 0.
- R7: The instruction layout is as follows. Bits 15:10 must be 000100. Bits 9:7 hold the opcode. Bit 6 is 1 for byte and 0 for word. Bits 5:4 hold the addressing mode, and 00 means register. Bits 3:0 name the register. On a write, `dst_o` carries bits 3:0.
- R8: `unsup_o` rises and `wr_en_o` and `flag_we_o` stay low in these cases: opcodes 100 to 111, a byte-form swap or sign extend, or an addressing mode other than 00.
- R9: A word whose bits 15:10 are not 000100 leaves `wr_en_o`, `flag_we_o` and `unsup_o` all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_i | input | 16 | Instruction word |
| opnd_i | input | 16 | Value of the addressed register |
| carry_i | input | 1 | Current carry flag |
| result_o | output | 16 | Result value |
| dst_o | output | 4 | Destination register number |
| wr_en_o | output | 1 | Register write strobe |
| flag_we_o | output | 1 | Flag write strobe |
| c_o | output | 1 | New carry flag |
| z_o | output | 1 | New zero flag |
| n_o | output | 1 | New negative flag |
| v_o | output | 1 | New overflow flag |
| unsup_o | output | 1 | Encoding not handled here |

## Verification
The hardest cases to reach from the ports are the ones where the carry flag is derived from the zero flag or from an operand bit that leaves the result. Examples are a rotate or shift that empties the register while setting C, and a sign extend of a value whose low byte is zero while its high byte is not. Table vectors set up each of these on purpose: operand 0x0001 with carry-in 0, and operand 0xFF00. Other vectors give byte-form operands non-zero upper bytes, which proves the upper half is cleared. The last directed test drops reset between clock edges and checks that the outputs clear before the next edge.

// File: rtl/sop_pkg.sv
package sop_pkg;
  localparam int unsigned INSTR_W = 16;
  localparam logic [5:0] FMT2_TAG = 6'b000100;

  typedef enum logic [2:0] {
    OP_RRC  = 3'b000,
    OP_SWAP = 3'b001,
    OP_RRA  = 3'b010,
    OP_SXT  = 3'b011,
    OP_PUSH = 3'b100,
    OP_CALL = 3'b101,
    OP_RETI = 3'b110,
    OP_NONE = 3'b111
  } sop_op_e;

  typedef struct packed {
    logic c;
    logic z;
    logic n;
    logic v;
  } flags_t;

  typedef struct packed {
    logic       fmt2;
    logic       legal;
    sop_op_e    op;
    logic       byte_m;
    logic [3:0] rsel;
  } dec_t;
endpackage

// File: rtl/sop_decode.sv
module sop_decode
  import sop_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  output dec_t               dec_o
);
  logic [1:0] mode;
  logic       fmt2;
  logic       byte_ok;
  sop_op_e    op;

  always_comb begin
    fmt2 = (instr_i[15:10] == FMT2_TAG);
    op   = sop_op_e'(instr_i[9:7]);
    mode = instr_i[5:4];
    unique case (op)
      OP_RRC, OP_RRA:   byte_ok = 1'b1;
      OP_SWAP, OP_SXT:  byte_ok = !instr_i[6];
      default:          byte_ok = 1'b0;
    endcase
    dec_o.fmt2   = fmt2;
    dec_o.op     = op;
    dec_o.byte_m = instr_i[6];
    dec_o.rsel   = instr_i[3:0];
    dec_o.legal  = fmt2 && (mode == 2'b00) && byte_ok;
  end
endmodule

// File: rtl/sop_alu.sv
module sop_alu
  import sop_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  sop_op_e            op_i,
  input  logic               byte_i,
  input  logic [DATA_W-1:0]  opnd_i,
  input  logic               carry_i,
  output logic [DATA_W-1:0]  res_o,
  output logic               flag_we_o,
  output flags_t             flags_o
);
  localparam int unsigned HALF_W = DATA_W / 2;
  localparam logic [HALF_W-1:0] HALF_ZERO = '0;

  logic cout;
  logic zero;

  always_comb begin
    res_o     = '0;
    cout      = carry_i;
    flag_we_o = 1'b0;
    unique case (op_i)
      OP_RRC: begin
        res_o     = byte_i ? {HALF_ZERO, carry_i, opnd_i[HALF_W-1:1]}
                           : {carry_i, opnd_i[DATA_W-1:1]};
        cout      = opnd_i[0];
        flag_we_o = 1'b1;
      end
      OP_RRA: begin
        res_o     = byte_i ? {HALF_ZERO, opnd_i[HALF_W-1], opnd_i[HALF_W-1:1]}
                           : {opnd_i[DATA_W-1], opnd_i[DATA_W-1:1]};
        cout      = opnd_i[0];
        flag_we_o = 1'b1;
      end
      OP_SWAP: res_o = {opnd_i[HALF_W-1:0], opnd_i[DATA_W-1:HALF_W]};
      OP_SXT: begin
        res_o     = {{HALF_W{opnd_i[HALF_W-1]}}, opnd_i[HALF_W-1:0]};
        flag_we_o = 1'b1;
      end
      default: ;
    endcase
    zero      = (res_o == '0);
    flags_o.z = zero;
    flags_o.n = byte_i ? res_o[HALF_W-1] : res_o[DATA_W-1];
    flags_o.c = (op_i == OP_SXT) ? !zero : cout;
    flags_o.v = 1'b0;
  end
endmodule

// File: rtl/sop_shift_unit.sv
module sop_shift_unit
  import sop_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [15:0]       instr_i,
  input  logic [DATA_W-1:0] opnd_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] result_o,
  output logic [3:0]        dst_o,
  output logic              wr_en_o,
  output logic              flag_we_o,
  output logic              c_o,
  output logic              z_o,
  output logic              n_o,
  output logic              v_o,
  output logic              unsup_o
);
  localparam int unsigned HALF_W = DATA_W / 2;

  dec_t              dec;
  logic [DATA_W-1:0] alu_res;
  logic              alu_fwe;
  flags_t            alu_flags;
  flags_t            flags_q;
  logic              byte_q;
  logic              sxt_q;

  sop_decode u_dec (
    .instr_i (instr_i),
    .dec_o   (dec)
  );

  sop_alu #(.DATA_W(DATA_W)) u_alu (
    .op_i      (dec.op),
    .byte_i    (dec.byte_m),
    .opnd_i    (opnd_i),
    .carry_i   (carry_i),
    .res_o     (alu_res),
    .flag_we_o (alu_fwe),
    .flags_o   (alu_flags)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o  <= '0;
      dst_o     <= '0;
      wr_en_o   <= 1'b0;
      flag_we_o <= 1'b0;
      unsup_o   <= 1'b0;
      flags_q   <= '0;
      byte_q    <= 1'b0;
      sxt_q     <= 1'b0;
    end else begin
      result_o  <= dec.legal ? alu_res : '0;
      dst_o     <= dec.legal ? dec.rsel : '0;
      wr_en_o   <= dec.legal;
      flag_we_o <= dec.legal && alu_fwe;
      unsup_o   <= dec.fmt2 && !dec.legal;
      flags_q   <= (dec.legal && alu_fwe) ? alu_flags : '0;
      byte_q    <= dec.byte_m;
      sxt_q     <= dec.op == OP_SXT;
    end
  end

  assign c_o = flags_q.c;
  assign z_o = flags_q.z;
  assign n_o = flags_q.n;
  assign v_o = flags_q.v;

  a_r8_unsup_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unsup_o |-> !wr_en_o && !flag_we_o);

  a_r4_swap_no_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec.legal && dec.op == OP_SWAP) |=> wr_en_o && !flag_we_o);

  a_r2_byte_upper_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && byte_q) |-> result_o[DATA_W-1:HALF_W] == '0);

  a_r5_sxt_carry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_we_o && sxt_q) |-> c_o == !z_o);

  a_r6_zero_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_we_o |-> z_o == (result_o == '0) && !v_o);

  a_r9_foreign_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dec.fmt2 |=> !wr_en_o && !unsup_o && !flag_we_o);
endmodule

// File: tb/sim_sop_shift_unit.sv
`timescale 1ns/1ps
module sim_sop_shift_unit;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] instr = '0;
  logic [15:0] opnd = '0;
  logic        cin = 1'b0;
  logic [15:0] result;
  logic [3:0]  dst;
  logic        wr_en, flag_we, c, z, n, v, unsup;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sop_shift_unit u0 (
    .clk_i(clk), .rst_ni(rst_ni), .instr_i(instr), .opnd_i(opnd), .carry_i(cin),
    .result_o(result), .dst_o(dst), .wr_en_o(wr_en), .flag_we_o(flag_we),
    .c_o(c), .z_o(z), .n_o(n), .v_o(v), .unsup_o(unsup)
  );

  // {instr, operand, carry_in, result, wr, unsup, flag_we, {c,z,n,v}}
  localparam int NV = 20;
  localparam logic [55:0] VEC [NV] = '{
    {16'h1005, 16'h0001, 1'b1, 16'h8000, 1'b1, 1'b0, 1'b1, 4'b1010},
    {16'h1005, 16'h0002, 1'b0, 16'h0001, 1'b1, 1'b0, 1'b1, 4'b0000},
    {16'h1045, 16'hAB01, 1'b1, 16'h0080, 1'b1, 1'b0, 1'b1, 4'b1010},
    {16'h1005, 16'h0001, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b1, 4'b1100},
    {16'h108C, 16'h12AB, 1'b0, 16'hAB12, 1'b1, 1'b0, 1'b0, 4'b0000},
    {16'h1107, 16'h8003, 1'b0, 16'hC001, 1'b1, 1'b0, 1'b1, 4'b1010},
    {16'h1147, 16'hFF84, 1'b1, 16'h00C2, 1'b1, 1'b0, 1'b1, 4'b0010},
    {16'h1107, 16'h0001, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b1, 4'b1100},
    {16'h118A, 16'h00AA, 1'b0, 16'hFFAA, 1'b1, 1'b0, 1'b1, 4'b1010},
    {16'h118A, 16'hFF00, 1'b1, 16'h0000, 1'b1, 1'b0, 1'b1, 4'b0100},
    {16'h118A, 16'h007F, 1'b0, 16'h007F, 1'b1, 1'b0, 1'b1, 4'b1000},
    {16'h10CC, 16'h1234, 1'b0, 16'h0000, 1'b0, 1'b1, 1'b0, 4'b0000},
    {16'h11CA, 16'h1234, 1'b0, 16'h0000, 1'b0, 1'b1, 1'b0, 4'b0000},
    {16'h1205, 16'h1234, 1'b0, 16'h0000, 1'b0, 1'b1, 1'b0, 4'b0000},
    {16'h1280, 16'h1234, 1'b0, 16'h0000, 1'b0, 1'b1, 1'b0, 4'b0000},
    {16'h1300, 16'h1234, 1'b0, 16'h0000, 1'b0, 1'b1, 1'b0, 4'b0000},
    {16'h1380, 16'h1234, 1'b0, 16'h0000, 1'b0, 1'b1, 1'b0, 4'b0000},
    {16'h1015, 16'h0002, 1'b0, 16'h0000, 1'b0, 1'b1, 1'b0, 4'b0000},
    {16'h4A09, 16'h5555, 1'b1, 16'h0000, 1'b0, 1'b0, 1'b0, 4'b0000},
    {16'h1045, 16'h00FE, 1'b0, 16'h007F, 1'b1, 1'b0, 1'b1, 4'b0000}
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [15:0] ins, input logic uns);
    if (uns)                    return "R8";
    if (ins[15:10] != 6'b000100) return "R9";
    case (ins[9:7])
      3'b000:  return "R2";
      3'b001:  return "R4";
      3'b010:  return "R3";
      default: return "R5";
    endcase
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "reset outputs", {result, dst, wr_en, flag_we, c, z, n, v, unsup}, '0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [55:0] e;
      string t;
      e = VEC[i];
      @(negedge clk);
      instr = e[55:40]; opnd = e[39:24]; cin = e[23];
      @(negedge clk);
      t = tag_of(e[55:40], e[5]);
      check(t, "wr_en", wr_en, e[6]);
      check(t, "unsup", unsup, e[5]);
      check(t, "flag_we", flag_we, e[4]);
      if (e[6]) begin
        check(t, "result", result, e[22:7]);
        check("R7", "dst", dst, e[43:40]);
      end
      if (e[4]) check("R6", "flags", {c, z, n, v}, e[3:0]);
    end

    // R1: one-cycle latency, output holds until the edge
    @(negedge clk);
    instr = 16'h118A; opnd = 16'h0080; cin = 1'b0;
    @(negedge clk);
    check("R1", "sxt result", result, 16'hFF80);
    instr = 16'h1080; opnd = 16'h00FF;
    #1;
    check("R1", "held before edge", result, 16'hFF80);
    @(negedge clk);
    check("R1", "swap after edge", result, 16'hFF00);

    // R1: asynchronous reset mid-cycle
    #1 rst_ni = 1'b0;
    #0.5;
    check("R1", "async clear", {result, wr_en}, '0);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    finish_run();
  end
endmodule